// File: doc/BRIEF.md
# Scanline Memory Slot Sequencer

This block sets the order of video-memory accesses across one scanline of a tile-and-sprite display controller running in its legacy character mode. Each clock is one access slot, and a line holds 171 slots. For every slot the block reports its position in the line, what kind of access belongs there, which sprite or column the access serves, and which half of a four-byte pattern row is fetched. It also drives the horizontal sync level, and it raises a grant in every slot that is left free for the host processor. A memory controller uses these strobes to steer its address mux and to schedule processor traffic.

The line is built from phases that a state machine walks through in a fixed loop:
- `PH_SPR_LO`: sprite fetch for active sprites 0–3 (12 slots).
- `PH_GAP_SYNC`: 5 free slots, with sync falling on the third.
- `PH_SPR_HI`: sprite fetch for active sprites 4–7 (12 slots).
- `PH_GAP_PRE`: 2 free slots.
- `PH_Y_SCAN`: 8 vertical-position reads for sprite pairs 0–15.
- `PH_BG`: eight 16-slot background groups, with more vertical-position reads woven in.
- `PH_TAIL`: 4 free slots.

Each phase moves to the next one when its last slot ends, and `PH_TAIL` returns to `PH_SPR_LO`. Active lines contain no refresh. On blanking lines every slot that is not free is reported as a refresh, and the free slots stay where they are.

Top module: `vram_slot_sched`

## Requirements
- R1: `slot_idx` is 0 during reset and while reset is held. It then steps by one per clock from 0 to 170 and goes back to 0 after 170.
- R2: `eol` is high during slot 170 and low in every other slot.
- R3: Slots 0–11 serve active sprites 0–3, and slots 17–28 serve active sprites 4–7. Each block of 6 slots serves a sprite pair (n, n+1) in this order: position read for n, position read for n+1 (code 1), then pattern words 0 and 1 for n, then pattern words 0 and 1 for n+1 (code 2). `word_sel` gives the word.
- R4: The free slots are 12–16, 29–30 and 167–170, plus the second slot of each background group. In a free slot `acc_type` is 0, `acc_idx` and `word_sel` are 0, and `ext_grant` is 1. `ext_grant` is 0 in every other slot.
- R5: Slot 31+i, for i from 0 to 7, is a vertical-position read (code 5) of the sprite pair that starts at 2·i.
- R6: Slots 39–166 form 32 columns of 4 slots each. Column c starts at slot 39+4c. Its first slot is a name read (code 3) with index c. Its third and fourth slots are pattern reads (code 4) with index c and words 0 and 1.
- R7: In background group b (columns 4b to 4b+3), the second slot of column 4b+k for k from 1 to 3 is a vertical-position read of the pair that starts at 14+6b+2k. Across one line, each of the 32 even pair starts from 0 to 62 is read exactly once.
- R8: `hsync_n` is low in slots 14–26 and high in all other slots.
- R9: While `vblank` is 0, no slot carries the refresh code 6. While `vblank` is 1, every non-free slot reports code 6 with index 0 and word 0. Free slots, `hsync_n` and `eol` are the same as on an active line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| vblank | input | 1 | High on blanking lines |
| slot_idx | output | 8 | Position in the line, 0–170 |
| acc_type | output | 3 | Access code: 0 free, 1 sprite position, 2 sprite pattern, 3 name, 4 background pattern, 5 vertical read, 6 refresh |
| acc_idx | output | 6 | Sprite, pair or column index |
| word_sel | output | 1 | Pattern word half |
| ext_grant | output | 1 | Free slot offered to the host |
| hsync_n | output | 1 | Horizontal sync, active low |
| eol | output | 1 | Last slot of the line |

## Verification
Two effects can land on the same slot. The blanking override can meet a free slot inside a background group, and the end-of-line pulse can meet the wrap of the phase machine. The bench sweeps every slot of an active line, then a blanking line, then another active line, comparing each output with a slot-arithmetic model. In blanking, free slots must keep their grant and every other slot must turn into refresh. At slot 170, `eol` must be high in the same cycle that the next clock returns both the counter and the phase to the line start.

// File: rtl/vsched_pkg.sv
package vsched_pkg;
    localparam int LINE_SLOTS = 171;
    localparam int SLOT_W     = 8;
    localparam int IDX_W      = 6;
    localparam int OFS_W      = 7;

    localparam int LEN_SPR      = 12;
    localparam int LEN_GAP_SYNC = 5;
    localparam int LEN_GAP_PRE  = 2;
    localparam int LEN_Y_SCAN   = 8;
    localparam int LEN_BG       = 128;
    localparam int LEN_TAIL     = 4;

    localparam int HS_FALL_OFS  = 2;   // offset inside PH_GAP_SYNC
    localparam int HS_RISE_OFS  = 10;  // offset inside PH_SPR_HI
    localparam int SPR_HI_BASE  = 4;
    localparam int BG_Y_BASE    = 14;

    typedef enum logic [2:0] {
        ACC_EXT     = 3'd0,
        ACC_SPR_POS = 3'd1,
        ACC_SPR_PAT = 3'd2,
        ACC_BG_NAME = 3'd3,
        ACC_BG_PAT  = 3'd4,
        ACC_SPR_Y   = 3'd5,
        ACC_REFRESH = 3'd6
    } acc_t;

    typedef enum logic [2:0] {
        PH_SPR_LO,
        PH_GAP_SYNC,
        PH_SPR_HI,
        PH_GAP_PRE,
        PH_Y_SCAN,
        PH_BG,
        PH_TAIL
    } phase_t;
endpackage

// File: rtl/vsched_ctr.sv
module vsched_ctr
    import vsched_pkg::*;
#(
    parameter int SLOTS = LINE_SLOTS,
    parameter int W     = SLOT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] slot,
    output logic         last
);
    localparam logic [W-1:0] LAST_SLOT = W'(SLOTS - 1);

    assign last = (slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (!rst_n)    slot <= '0;
        else if (last) slot <= '0;
        else           slot <= slot + 1'b1;
    end
endmodule

// File: rtl/vsched_fsm.sv
module vsched_fsm
    import vsched_pkg::*;
#(
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    output phase_t        phase,
    output logic [OW-1:0] ofs
);
    phase_t        phase_nx;
    logic [OW-1:0] ofs_nx;
    logic [OW-1:0] len_m1;

    always_comb begin
        unique case (phase)
            PH_SPR_LO:   len_m1 = OW'(LEN_SPR - 1);
            PH_GAP_SYNC: len_m1 = OW'(LEN_GAP_SYNC - 1);
            PH_SPR_HI:   len_m1 = OW'(LEN_SPR - 1);
            PH_GAP_PRE:  len_m1 = OW'(LEN_GAP_PRE - 1);
            PH_Y_SCAN:   len_m1 = OW'(LEN_Y_SCAN - 1);
            PH_BG:       len_m1 = OW'(LEN_BG - 1);
            PH_TAIL:     len_m1 = OW'(LEN_TAIL - 1);
            default:     len_m1 = '0;
        endcase
    end

    always_comb begin
        phase_nx = phase;
        ofs_nx   = ofs + 1'b1;
        if (ofs == len_m1) begin
            ofs_nx = '0;
            unique case (phase)
                PH_SPR_LO:   phase_nx = PH_GAP_SYNC;
                PH_GAP_SYNC: phase_nx = PH_SPR_HI;
                PH_SPR_HI:   phase_nx = PH_GAP_PRE;
                PH_GAP_PRE:  phase_nx = PH_Y_SCAN;
                PH_Y_SCAN:   phase_nx = PH_BG;
                PH_BG:       phase_nx = PH_TAIL;
                PH_TAIL:     phase_nx = PH_SPR_LO;
                default:     phase_nx = PH_SPR_LO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_SPR_LO;
            ofs   <= '0;
        end else begin
            phase <= phase_nx;
            ofs   <= ofs_nx;
        end
    end
endmodule

// File: rtl/vsched_dec.sv
module vsched_dec
    import vsched_pkg::*;
#(
    parameter int OW = OFS_W,
    parameter int IW = IDX_W
) (
    input  phase_t        phase,
    input  logic [OW-1:0] ofs,
    output acc_t          kind,
    output logic [IW-1:0] idx,
    output logic          word,
    output logic          hs_n
);
    logic          pair_hi;
    logic [3:0]    rem;
    logic [IW-1:0] spr_base;
    logic [2:0]    grp;
    logic [1:0]    col_k;
    logic [1:0]    col_j;

    always_comb begin
        pair_hi  = (ofs >= OW'(6));
        rem      = ofs[3:0] - (pair_hi ? 4'd6 : 4'd0);
        spr_base = ((phase == PH_SPR_HI) ? IW'(SPR_HI_BASE) : '0) + (pair_hi ? IW'(2) : '0);
        grp      = ofs[6:4];
        col_k    = ofs[3:2];
        col_j    = ofs[1:0];
    end

    always_comb begin
        kind = ACC_EXT;
        idx  = '0;
        word = 1'b0;
        unique case (phase)
            PH_SPR_LO, PH_SPR_HI: begin
                unique case (rem)
                    4'd0: begin kind = ACC_SPR_POS; idx = spr_base; end
                    4'd1: begin kind = ACC_SPR_POS; idx = spr_base + 1'b1; end
                    4'd2: begin kind = ACC_SPR_PAT; idx = spr_base; end
                    4'd3: begin kind = ACC_SPR_PAT; idx = spr_base; word = 1'b1; end
                    4'd4: begin kind = ACC_SPR_PAT; idx = spr_base + 1'b1; end
                    4'd5: begin kind = ACC_SPR_PAT; idx = spr_base + 1'b1; word = 1'b1; end
                    default: kind = ACC_EXT;
                endcase
            end
            PH_Y_SCAN: begin
                kind = ACC_SPR_Y;
                idx  = IW'({ofs[2:0], 1'b0});
            end
            PH_BG: begin
                unique case (col_j)
                    2'd0: begin kind = ACC_BG_NAME; idx = IW'(ofs[6:2]); end
                    2'd1: begin
                        if (col_k != 2'd0) begin
                            kind = ACC_SPR_Y;
                            idx  = IW'(BG_Y_BASE) + IW'(grp) * IW'(6) + IW'({col_k, 1'b0});
                        end
                    end
                    default: begin
                        kind = ACC_BG_PAT;
                        idx  = IW'(ofs[6:2]);
                        word = col_j[0];
                    end
                endcase
            end
            PH_GAP_SYNC, PH_GAP_PRE, PH_TAIL: kind = ACC_EXT;
            default: kind = ACC_EXT;
        endcase
    end

    always_comb begin
        hs_n = 1'b1;
        if (phase == PH_GAP_SYNC && ofs >= OW'(HS_FALL_OFS)) hs_n = 1'b0;
        if (phase == PH_SPR_HI   && ofs <  OW'(HS_RISE_OFS)) hs_n = 1'b0;
    end
endmodule

// File: rtl/vram_slot_sched.sv
module vram_slot_sched
    import vsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vblank,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [2:0]        acc_type,
    output logic [IDX_W-1:0]  acc_idx,
    output logic              word_sel,
    output logic              ext_grant,
    output logic              hsync_n,
    output logic              eol
);
    phase_t             phase;
    logic [OFS_W-1:0]   ofs;
    acc_t               kind;
    logic [IDX_W-1:0]   idx;
    logic               word;

    vsched_ctr #(.SLOTS(LINE_SLOTS), .W(SLOT_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .slot (slot_idx),
        .last (eol)
    );

    vsched_fsm #(.OW(OFS_W)) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .phase(phase),
        .ofs  (ofs)
    );

    vsched_dec #(.OW(OFS_W), .IW(IDX_W)) u_dec (
        .phase(phase),
        .ofs  (ofs),
        .kind (kind),
        .idx  (idx),
        .word (word),
        .hs_n (hsync_n)
    );

    always_comb begin
        ext_grant = (kind == ACC_EXT);
        if (vblank && !ext_grant) begin
            acc_type = ACC_REFRESH;
            acc_idx  = '0;
            word_sel = 1'b0;
        end else begin
            acc_type = kind;
            acc_idx  = idx;
            word_sel = word;
        end
    end
endmodule

// File: rtl/vsched_chk.sv
module vsched_chk
    import vsched_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              vblank,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [2:0]        acc_type,
    input logic [IDX_W-1:0]  acc_idx,
    input logic              word_sel,
    input logic              ext_grant,
    input logic              hsync_n,
    input logic              eol
);
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == SLOT_W'(LINE_SLOTS - 1)) |=> (slot_idx == '0)); // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != SLOT_W'(LINE_SLOTS - 1)) |=> (slot_idx == $past(slot_idx) + 1'b1)); // R1
    AST_EOL_START: assert property (@(posedge clk) disable iff (!rst_n)
        eol |=> (slot_idx == '0 && acc_type != 3'(ACC_EXT))); // R2
    AST_HSYNC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> (slot_idx == SLOT_W'(14))); // R8
    AST_HSYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (slot_idx == SLOT_W'(27))); // R8
    AST_NO_ACTIVE_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank |-> (acc_type != 3'(ACC_REFRESH))); // R9
    AST_BLANK_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && !ext_grant) |-> (acc_type == 3'(ACC_REFRESH) && acc_idx == '0)); // R9
    AST_PAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type == 3'(ACC_SPR_PAT) && word_sel) |->
        ($past(acc_type) == 3'(ACC_SPR_PAT) && !$past(word_sel) && $past(acc_idx) == acc_idx)); // R3
endmodule

bind vram_slot_sched vsched_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vblank   (vblank),
    .slot_idx (slot_idx),
    .acc_type (acc_type),
    .acc_idx  (acc_idx),
    .word_sel (word_sel),
    .ext_grant(ext_grant),
    .hsync_n  (hsync_n),
    .eol      (eol)
);

// File: tb/vram_slot_sched_test.sv
`timescale 1ns/1ps
module vram_slot_sched_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vblank = 1'b0;
    logic [7:0] slot_idx;
    logic [2:0] acc_type;
    logic [5:0] acc_idx;
    logic       word_sel, ext_grant, hsync_n, eol;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vram_slot_sched uut (
        .clk(clk), .rst_n(rst_n), .vblank(vblank),
        .slot_idx(slot_idx), .acc_type(acc_type), .acc_idx(acc_idx),
        .word_sel(word_sel), .ext_grant(ext_grant), .hsync_n(hsync_n), .eol(eol)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Arithmetic model of one slot on an active line: type, index, word
    task automatic model(input int s, output int t, output int ix, output int w);
        t = 0; ix = 0; w = 0;
        if (s < 12 || (s >= 17 && s < 29)) begin
            int o, base, r;
            o    = (s < 12) ? s : s - 17;
            base = ((s < 12) ? 0 : 4) + 2 * (o / 6);
            r    = o % 6;
            if (r < 2) begin t = 1; ix = base + r; end
            else begin t = 2; ix = base + (r - 2) / 2; w = r % 2; end
        end else if (s >= 31 && s < 39) begin
            t = 5; ix = 2 * (s - 31);
        end else if (s >= 39 && s < 167) begin
            int o, c, j, b, k;
            o = s - 39; c = o / 4; j = o % 4; b = c / 4; k = c % 4;
            if (j == 0) begin t = 3; ix = c; end
            else if (j == 1) begin
                if (k != 0) begin t = 5; ix = 14 + 6 * b + 2 * k; end
            end else begin t = 4; ix = c; w = j - 2; end
        end
    endtask

    initial begin
        #900000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] seen;
        int ext_cnt;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // Reset state: R1
        chk("R1", "reset slot", int'(slot_idx), 0);
        chk("R3", "reset type", int'(acc_type), 1);
        chk("R8", "reset hsync", int'(hsync_n), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "held reset slot", int'(slot_idx), 0);
        rst_n = 1'b1;
        seen = '0;
        ext_cnt = 0;
        for (int c = 0; c < 3 * 171; c++) begin
            int s, line, t, ix, w, et, eix, ew;
            s = c % 171; line = c / 171;
            if (s == 0) begin
                vblank = (line == 1);
                seen = '0;
                ext_cnt = 0;
                #0.1;
            end
            model(s, t, ix, w);
            chk("R1", "slot", int'(slot_idx), s);
            chk("R2", "eol", int'(eol), (s == 170) ? 1 : 0);
            chk("R8", "hsync_n", int'(hsync_n), (s >= 14 && s <= 26) ? 0 : 1);
            chk("R4", "ext_grant", int'(ext_grant), (t == 0) ? 1 : 0);
            if (vblank && t != 0) begin
                et = 6; eix = 0; ew = 0;
            end else begin
                et = t; eix = ix; ew = w;
            end
            if (s < 29)                     chk("R3", "type", int'(acc_type), et);
            else if (s >= 31 && s < 39)     chk("R5", "type", int'(acc_type), et);
            else if (s >= 39 && s < 167)    chk("R6", "type", int'(acc_type), et);
            else                            chk("R4", "type", int'(acc_type), et);
            if (vblank)                     chk("R9", "blank type", int'(acc_type), et);
            if (t == 5 && s >= 39)          chk("R7", "pair idx", int'(acc_idx), eix);
            else                            chk("R6", "index", int'(acc_idx), eix);
            chk("R3", "word", int'(word_sel), ew);
            if (!vblank) begin
                chk("R9", "no refresh active", (acc_type == 3'd6) ? 1 : 0, 0);
                if (acc_type == 3'd5) begin
                    chk("R7", "pair read once", int'(seen[acc_idx]), 0);
                    seen[acc_idx] = 1'b1;
                end
            end
            if (ext_grant) ext_cnt++;
            if (s == 170) begin
                chk("R4", "free slots per line", ext_cnt, 19);
                if (!vblank) chk("R7", "all pairs seen", (seen == 64'h5555_5555_5555_5555) ? 1 : 0, 1);
            end
            @(negedge clk);
        end
        // After three lines the counter is back at the line start: R1
        chk("R1", "wrap after lines", int'(slot_idx), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule